// File: doc/BRIEF.md
# Escape-Coded Run-Length Byte Expander

This block rebuilds a configuration image from a compact byte stream. Most bytes are copied straight through. The two saturated byte values, all-zeros and all-ones, are escape codes. When one of them arrives, the next byte is read as a repeat count, and the block then emits that many copies of the escape value. A count of zero stands for 256 copies, so every count code means something.

Both edges of the block are valid/ready byte streams. A byte moves on a rising clock edge at which valid and ready are both high. A byte the block has offered stays on the output, unchanged, until the downstream side takes it. The block never buffers more than one output byte. While a run is being produced, the block stops taking input until the final copy of the run has gone downstream. The upstream side marks the final byte of an image with an end-of-stream flag. If that final byte is an escape code, it has no count to follow it, so the block raises a sticky error flag and emits nothing for it.

Top module: `rle_expander`

## Requirements
- R1: Any input byte other than 0x00 and 0xFF appears unchanged on `out_data`, with `out_valid` high, in the cycle after it is accepted. Bytes leave in the order they arrived.
- R2: An accepted 0x00 or 0xFF byte (with `in_last` low) produces no output itself. The next accepted byte is a count N, and the block then emits N copies of the escape value.
- R3: A count byte of 0x01 yields exactly one copy of the escape value.
- R4: A count byte of 0x00 yields exactly 256 copies of the escape value.
- R5: `in_ready` is low from the cycle after a count byte greater than one is accepted. It stays low until the cycle in which the final copy of the run is offered with `out_ready` high.
- R6: With `out_ready` held high, the first copy of a run is valid in the cycle after the count is accepted, and the copies follow on consecutive cycles with no gap.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change in the next cycle.
- R8: An escape byte accepted with `in_last` high sets `err_orphan` in the next cycle and produces no output. The flag stays set until reset, and later bytes are processed normally.
- R9: A synchronous reset (`rst` high at a rising edge) clears `out_valid`, `err_orphan`, any pending escape and any run in progress. The byte that follows the reset is treated as a new first byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream byte is present |
| in_ready | output | 1 | Block will take the upstream byte at this edge |
| in_data | input | 8 | Compressed stream byte |
| in_last | input | 1 | Marks the final byte of an image |
| out_valid | output | 1 | Expanded byte is present |
| out_ready | input | 1 | Downstream takes the byte at this edge |
| out_data | output | 8 | Expanded stream byte |
| err_orphan | output | 1 | Sticky: the image ended on an escape byte with no count |

## Verification
Every output of the block comes from a single register, so each result is due one edge after its cause. A literal is valid in the cycle after it is accepted. The first copy of a run is valid in the cycle after its count is accepted. The error flag rises in the cycle after an orphan escape. When the downstream side is ready, `in_ready` returns in the cycle that offers the final copy of a run. The bench drives inputs and samples outputs shortly after the falling edge. For the run-timing test it reads a fixed window of cycles counted from the edge that accepted the count. For the sweeps it compares the collected output stream with a stream computed from the counts.

// File: rtl/rle_pkg.sv
package rle_pkg;
  typedef enum logic [1:0] {
    ST_LIT = 2'd0,
    ST_CNT = 2'd1,
    ST_RUN = 2'd2
  } rle_state_e;
endpackage

// File: rtl/rle_esc_detect.sv
module rle_esc_detect #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  output logic              is_esc_o
);
  localparam logic [DATA_W-1:0] ALL_ZERO = '0;
  localparam logic [DATA_W-1:0] ALL_ONE  = '1;

  assign is_esc_o = (byte_i == ALL_ZERO) || (byte_i == ALL_ONE);
endmodule

// File: rtl/rle_run_counter.sv
module rle_run_counter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] count_i,
  input  logic              step_i,
  output logic              final_o
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  // remaining copies after the one currently held in the output register;
  // count-1 wraps so a count of zero loads the full 2**DATA_W - 1
  logic [DATA_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
    end else if (load_i) begin
      remain_q <= count_i - ONE;
    end else if (step_i) begin
      remain_q <= remain_q - ONE;
    end
  end

  assign final_o = (remain_q == ONE);
endmodule

// File: rtl/rle_out_stage.sv
module rle_out_stage #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              ready_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] data_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      data_o  <= '0;
    end else if (load_i) begin
      valid_o <= 1'b1;
      data_o  <= data_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/rle_expander.sv
module rle_expander
  import rle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              err_orphan
);
  localparam logic [DATA_W-1:0] CNT_ONE = DATA_W'(1);

  rle_state_e        st, st_nxt;
  logic [DATA_W-1:0] esc_val;
  logic              is_esc;
  logic              take_in;
  logic              slot_free;
  logic              run_final;
  logic              ld_out;
  logic [DATA_W-1:0] ld_data;
  logic              cnt_load;
  logic              cnt_step;

  rle_esc_detect #(.DATA_W(DATA_W)) u_detect (
    .byte_i   (in_data),
    .is_esc_o (is_esc)
  );

  assign slot_free = !out_valid || out_ready;
  assign in_ready  = (st != ST_RUN) && slot_free;
  assign take_in   = in_valid && in_ready;

  always_comb begin
    st_nxt   = st;
    ld_out   = 1'b0;
    ld_data  = in_data;
    cnt_load = 1'b0;
    cnt_step = 1'b0;
    unique case (st)
      ST_LIT: begin
        if (take_in) begin
          if (!is_esc) begin
            ld_out = 1'b1;
          end else if (!in_last) begin
            st_nxt = ST_CNT;
          end
        end
      end
      ST_CNT: begin
        if (take_in) begin
          ld_out   = 1'b1;
          ld_data  = esc_val;
          cnt_load = 1'b1;
          st_nxt   = (in_data == CNT_ONE) ? ST_LIT : ST_RUN;
        end
      end
      ST_RUN: begin
        if (out_ready) begin
          ld_out   = 1'b1;
          ld_data  = esc_val;
          cnt_step = 1'b1;
          if (run_final) st_nxt = ST_LIT;
        end
      end
      default: st_nxt = ST_LIT;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= ST_LIT;
      esc_val    <= '0;
      err_orphan <= 1'b0;
    end else begin
      st <= st_nxt;
      if (st == ST_LIT && take_in && is_esc) begin
        esc_val <= in_data;
        if (in_last) err_orphan <= 1'b1;
      end
    end
  end

  rle_run_counter #(.DATA_W(DATA_W)) u_counter (
    .clk     (clk),
    .rst     (rst),
    .load_i  (cnt_load),
    .count_i (in_data),
    .step_i  (cnt_step),
    .final_o (run_final)
  );

  rle_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load_i  (ld_out),
    .data_i  (ld_data),
    .ready_i (out_ready),
    .valid_o (out_valid),
    .data_o  (out_data)
  );
endmodule

// File: rtl/rle_expander_chk.sv
module rle_expander_chk
  import rle_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_data,
  input logic              in_last,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_data,
  input logic              err_orphan,
  input rle_state_e        st
);
  logic esc_in;
  assign esc_in = (in_data == '0) || (in_data == '1);

  // R1
  literal_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && st == ST_LIT && !esc_in)
      |=> (out_valid && out_data == $past(in_data)));

  // R2
  esc_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && st == ST_LIT && esc_in && !in_last)
      |=> (!out_valid && st == ST_CNT));

  // R5
  run_hold_input_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RUN) |-> !in_ready);

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  orphan_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && st == ST_LIT && esc_in && in_last)
      |=> (err_orphan && !out_valid));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    err_orphan |=> err_orphan);

  // R9
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !err_orphan && st == ST_LIT));
endmodule

bind rle_expander rle_expander_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_data    (in_data),
  .in_last    (in_last),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_data   (out_data),
  .err_orphan (err_orphan),
  .st         (st)
);

// File: tb/test_rle_expander.sv
`timescale 1ns/1ps
module test_rle_expander;
  logic       clk = 1'b0;
  logic       rst;
  logic       in_valid, in_ready, in_last;
  logic [7:0] in_data;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [7:0] out_data;
  logic       err_orphan;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int rdy_mode = 0;
  logic       prev_stall = 1'b0;
  logic [7:0] prev_data  = 8'h00;
  logic [7:0] expq[$];
  logic [7:0] gotq[$];

  always #2.5 clk = ~clk;

  rle_expander i_rle_expander (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .err_orphan(err_orphan)
  );

  // downstream model: sets ready at the falling edge, then samples
  always begin
    @(negedge clk);
    cyc++;
    out_ready = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) != 0);
    #1;
    if (prev_stall) begin
      checks++;
      if (!(out_valid && out_data == prev_data)) begin
        fails++;
        $display("FAIL R7 stall hold: valid=%0b data=%02h expected valid=1 data=%02h",
                 out_valid, out_data, prev_data);
      end
    end
    prev_stall = !rst && out_valid && !out_ready;
    prev_data  = out_data;
    if (!rst && out_valid && out_ready) gotq.push_back(out_data);
  end

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic check(input string tag, input logic ok, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic l);
    @(negedge clk);
    in_valid = 1'b1; in_data = b; in_last = l;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (gotq.size() < expq.size() && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    int bad = -1;
    checks++;
    if (gotq.size() == expq.size()) begin
      foreach (expq[i]) if (bad < 0 && gotq[i] !== expq[i]) bad = i;
    end
    if (gotq.size() != expq.size()) begin
      fails++;
      $display("FAIL %s stream length actual=%0d expected=%0d", tag, gotq.size(), expq.size());
    end else if (bad >= 0) begin
      fails++;
      $display("FAIL %s byte %0d actual=%02h expected=%02h", tag, bad, gotq[bad], expq[bad]);
    end
    expq.delete();
    gotq.delete();
  endtask

  task automatic run_case(input logic [7:0] v, input logic [7:0] c);
    int reps = (c == 8'd0) ? 256 : int'(c);
    send(v, 1'b0);
    send(c, 1'b0);
    for (int k = 0; k < reps; k++) expq.push_back(v);
    drain();
    if (c == 8'd1)      compare("R3 count one");
    else if (c == 8'd0) compare("R4 count zero");
    else                compare("R2 run");
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end

  initial begin
    logic vs[6];
    logic rs[6];
    rst = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    // R9 reset state
    check("R9 reset out_valid", out_valid == 1'b0, out_valid, 0);
    check("R9 reset err_orphan", err_orphan == 1'b0, err_orphan, 0);
    check("R9 reset in_ready", in_ready == 1'b1, in_ready, 1);

    // R1 every literal value, full-rate and throttled downstream
    for (int pass = 0; pass < 2; pass++) begin
      rdy_mode = pass;
      for (int v = 1; v < 255; v++) begin
        send(8'(v), 1'b0);
        expq.push_back(8'(v));
      end
      drain();
      compare("R1 literals");
    end

    // R2 R3 R4 all counts for 0x00 at full rate, for 0xFF under back-pressure
    rdy_mode = 0;
    for (int c = 0; c < 256; c++) run_case(8'h00, 8'(c));
    rdy_mode = 1;
    for (int c = 0; c < 256; c++) run_case(8'hFF, 8'(c));

    // R2 interleaved literals and escapes
    rdy_mode = 1;
    send(8'h12, 1'b0); expq.push_back(8'h12);
    send(8'hFF, 1'b0); send(8'h03, 1'b0);
    repeat (3) expq.push_back(8'hFF);
    send(8'h34, 1'b0); expq.push_back(8'h34);
    send(8'h00, 1'b0); send(8'h01, 1'b0); expq.push_back(8'h00);
    send(8'hAB, 1'b0); expq.push_back(8'hAB);
    drain();
    compare("R2 mixed stream");

    // R5 R6 run timing with count 5, downstream always ready
    rdy_mode = 0;
    repeat (2) @(negedge clk);
    send(8'h00, 1'b0);
    send(8'h05, 1'b0);
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #2;
      vs[i] = out_valid;
      rs[i] = in_ready;
    end
    for (int i = 0; i < 6; i++)
      check($sformatf("R6 out_valid cycle %0d", i), vs[i] == (i < 5), vs[i], (i < 5));
    for (int i = 0; i < 5; i++)
      check($sformatf("R5 in_ready cycle %0d", i), rs[i] == (i == 4), rs[i], (i == 4));
    expq.delete(); gotq.delete();

    // R8 orphan escape at end of stream
    send(8'hFF, 1'b1);
    repeat (3) @(negedge clk);
    #2;
    check("R8 err_orphan set", err_orphan == 1'b1, err_orphan, 1);
    check("R8 no output", gotq.size() == 0, gotq.size(), 0);
    send(8'h41, 1'b0); expq.push_back(8'h41);
    drain();
    compare("R8 stream continues");
    check("R8 err_orphan sticky", err_orphan == 1'b1, err_orphan, 1);

    // R9 reset in the middle of a 256-byte run
    send(8'hFF, 1'b0);
    send(8'h00, 1'b0);
    repeat (10) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #2;
    check("R9 run abandoned out_valid", out_valid == 1'b0, out_valid, 0);
    check("R9 err cleared", err_orphan == 1'b0, err_orphan, 0);
    check("R9 in_ready back", in_ready == 1'b1, in_ready, 1);
    repeat (3) @(negedge clk);
    check("R9 run stays stopped", out_valid == 1'b0, out_valid, 0);
    expq.delete(); gotq.delete();

    // R9 pending escape discarded by reset
    send(8'h00, 1'b0);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    send(8'h07, 1'b0); expq.push_back(8'h07);
    drain();
    compare("R9 pending escape dropped");

    finish_up();
  end
endmodule